// File: doc/BRIEF.md
# Decoupled Four-Phase Latch Stage Controller

This block controls one stage of a handshake-driven pipeline. The stage holds one data word. Upstream and downstream talk to it through four-phase request/acknowledge pairs. On every wire the rising edge carries the meaning, and the falling edge is only the return to zero. The block is modelled as a clocked, synchronous state machine. Every handshake output is a register, and the data word is loaded at the same clock edge that closes the latch.

Two state bits keep the two sides of the stage apart. The first bit, latch-closed, records that a word has been captured. The second bit, output-busy, records that the downstream handshake for a word is still in progress. Because of this split, the upstream acknowledge can return to zero as soon as the word is captured, whatever the downstream side is doing. A new word is never presented downstream until the previous downstream handshake has fully returned to zero.

The parameter `LONG_HOLD` selects when the latch reopens. In the default variant it reopens as soon as downstream acknowledges. In the long-hold variant it stays closed, with the data steady, until the downstream acknowledge has returned low. This lets the request gate a consumer, such as an address decoder, for the whole output cycle.

Top module: `dcpl_latch_ctrl`

## Requirements
- R1: While `rst_n` is low, `ack_in`, `req_out` and `lat_closed` are 0.
- R2: At a clock edge where the latch is open, `ack_in` is low and `req_in` is high, the stage captures `data_in`. From that edge onward, `ack_in` and `lat_closed` are 1 and `data_out` equals the captured word.
- R3: `ack_in` stays high while `req_in` stays high. `ack_in` falls at the first edge where `req_in` is sampled low. Neither `ack_out` nor `req_out` has any influence on this.
- R4: While `lat_closed` stays high, `data_out` does not change, whatever `data_in` does.
- R5: `req_out` rises only while the latch is closed, `ack_out` is low and the previous output handshake has completed. It rises one edge after capture. Once high, it stays high until `ack_out` is sampled high, and it falls at that edge.
- R6: With `LONG_HOLD` = 0, the latch reopens (`lat_closed` goes to 0) at the same edge where `req_out` falls.
- R7: With `LONG_HOLD` = 1, the latch stays closed while `ack_out` is high. It reopens at the first edge where both `req_out` and `ack_out` are sampled low.
- R8: While the latch is closed or `ack_in` is high, a high `req_in` captures nothing. `ack_in` does not rise and `data_out` keeps the held word.
- R9: In a chain of stages, each word reaches the end exactly once and in the order it was sent. With the last consumer stalled, a chain of N stages accepts exactly N words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 1 | Upstream request: data_in is valid |
| ack_in | output | 1 | Upstream acknowledge: word captured |
| data_in | input | WIDTH | Upstream data word |
| req_out | output | 1 | Downstream request: data_out is valid |
| ack_out | input | 1 | Downstream acknowledge: word taken |
| data_out | output | WIDTH | Held data word |
| lat_closed | output | 1 | Latch enable; 1 means the word is held |

## Verification
The bench holds the downstream acknowledge low and then completes the upstream handshake. It checks that `ack_in` still returns to zero. A design that tied input recovery to the output side would keep `ack_in` high and stall the sender. It also raises a second request while a word is held, to catch a design that acknowledges without capturing or that overwrites the held word. Both reopen variants run from the same stimulus, which exposes a long-hold stage that reopens on the acknowledge rise and lets the data change while `req_out` still gates the consumer. A three-stage chain with random delays at both ends and a stalled sink checks that no word is lost, duplicated or reordered, and that every stage can fill.

// File: rtl/dcpl_pkg.sv
package dcpl_pkg;

    typedef struct packed {
        logic closed;
        logic ack;
    } in_state_t;

    typedef struct packed {
        logic req;
        logic busy;
    } out_state_t;

endpackage

// File: rtl/dcpl_in_side.sv
module dcpl_in_side
    import dcpl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic release_i,
    output logic closed_o,
    output logic ack_o,
    output logic load_o
);

    in_state_t st_d, st_q;
    logic      load;

    always_comb begin
        st_d = st_q;
        // A fresh word is taken only when the latch is open and the last
        // input handshake has returned to zero.
        load = !st_q.closed && !st_q.ack && req_in;
        if (st_q.closed) begin
            if (release_i) st_d.closed = 1'b0;
        end else if (load) begin
            st_d.closed = 1'b1;
        end
        // Input recovery depends on req_in only.
        if (st_q.ack) st_d.ack = req_in;
        else          st_d.ack = load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign closed_o = st_q.closed;
    assign ack_o    = st_q.ack;
    assign load_o   = load;

endmodule

// File: rtl/dcpl_out_side.sv
module dcpl_out_side
    import dcpl_pkg::*;
#(
    parameter bit LONG_HOLD = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic closed_i,
    input  logic ack_out,
    output logic req_out,
    output logic release_o
);

    out_state_t st_d, st_q;
    logic       rise;

    always_comb begin
        st_d = st_q;
        rise = closed_i && !st_q.busy && !st_q.req && !ack_out;
        if (st_q.req) st_d.req = !ack_out;
        else          st_d.req = rise;
        st_d.busy = rise || (st_q.busy && (st_q.req || ack_out));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (LONG_HOLD) begin : g_hold
            // Reopen only once the output handshake is back to zero.
            assign release_o = st_q.busy && !st_q.req && !ack_out;
        end else begin : g_early
            // Reopen as soon as downstream has taken the word.
            assign release_o = st_q.req && ack_out;
        end
    endgenerate

    assign req_out = st_q.req;

endmodule

// File: rtl/dcpl_data_hold.sv
module dcpl_data_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) word_d = d_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign q_o = word_q;

endmodule

// File: rtl/dcpl_latch_ctrl.sv
module dcpl_latch_ctrl #(
    parameter int WIDTH     = 8,
    parameter bit LONG_HOLD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    output logic             ack_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             req_out,
    input  logic             ack_out,
    output logic [WIDTH-1:0] data_out,
    output logic             lat_closed
);

    logic closed;
    logic load;
    logic release_w;

    dcpl_in_side u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .release_i (release_w),
        .closed_o  (closed),
        .ack_o     (ack_in),
        .load_o    (load)
    );

    dcpl_out_side #(.LONG_HOLD(LONG_HOLD)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .closed_i  (closed),
        .ack_out   (ack_out),
        .req_out   (req_out),
        .release_o (release_w)
    );

    dcpl_data_hold #(.WIDTH(WIDTH)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    (data_in),
        .q_o    (data_out)
    );

    assign lat_closed = closed;

endmodule

// File: rtl/dcpl_checker.sv
module dcpl_checker #(
    parameter int WIDTH     = 8,
    parameter bit LONG_HOLD = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_in,
    input logic             ack_in,
    input logic             req_out,
    input logic             ack_out,
    input logic             lat_closed,
    input logic [WIDTH-1:0] data_out
);

    a_r3_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in && req_in |=> ack_in);

    a_r3_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in && !req_in |=> !ack_in);

    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        lat_closed |=> (!lat_closed || $stable(data_out)));

    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req_out && !ack_out |=> req_out);

    a_r5_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        req_out && ack_out |=> !req_out);

    a_r5_req_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> lat_closed);

    a_r8_ack_with_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_in) |-> $rose(lat_closed));

    generate
        if (LONG_HOLD) begin : g_hold
            a_r7_hold_while_acked: assert property (@(posedge clk) disable iff (!rst_n)
                lat_closed && ack_out |=> lat_closed);
        end else begin : g_early
            a_r6_reopen_with_req: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(req_out) |-> !lat_closed);
        end
    endgenerate

endmodule

bind dcpl_latch_ctrl dcpl_checker #(.WIDTH(WIDTH), .LONG_HOLD(LONG_HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .ack_in     (ack_in),
    .req_out    (req_out),
    .ack_out    (ack_out),
    .lat_closed (lat_closed),
    .data_out   (data_out)
);

// File: tb/dcpl_latch_ctrl_bench.sv
module dcpl_latch_ctrl_bench;

    localparam int W      = 8;
    localparam int STAGES = 3;
    localparam int NWORDS = 60;
    localparam int LIMIT  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] base = 8'h00;

    // Directed pair: same inputs, both reopen variants
    logic         s_req = 1'b0, s_aout = 1'b0;
    logic [W-1:0] s_data = '0;
    logic         n_ack, n_rout, n_lat, h_ack, h_rout, h_lat;
    logic [W-1:0] n_dout, h_dout;

    dcpl_latch_ctrl #(.WIDTH(W), .LONG_HOLD(1'b0)) u_dcpl_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .req_in(s_req), .ack_in(n_ack), .data_in(s_data),
        .req_out(n_rout), .ack_out(s_aout), .data_out(n_dout), .lat_closed(n_lat));

    dcpl_latch_ctrl #(.WIDTH(W), .LONG_HOLD(1'b1)) u_hold (
        .clk(clk), .rst_n(rst_n), .req_in(s_req), .ack_in(h_ack), .data_in(s_data),
        .req_out(h_rout), .ack_out(s_aout), .data_out(h_dout), .lat_closed(h_lat));

    // Three-stage chain
    logic         rq [STAGES+1];
    logic         ak [STAGES+1];
    logic [W-1:0] dt [STAGES+1];
    logic         lt [STAGES];
    logic         p_req = 1'b0, p_aout = 1'b0;
    logic [W-1:0] p_data = '0;

    assign rq[0] = p_req;
    assign dt[0] = p_data;
    assign ak[STAGES] = p_aout;

    for (genvar g = 0; g < STAGES; g++) begin : g_pipe
        dcpl_latch_ctrl #(.WIDTH(W), .LONG_HOLD(1'b0)) u_stage (
            .clk(clk), .rst_n(rst_n), .req_in(rq[g]), .ack_in(ak[g]), .data_in(dt[g]),
            .req_out(rq[g+1]), .ack_out(ak[g+1]), .data_out(dt[g+1]), .lat_closed(lt[g]));
    end

    function automatic logic [W-1:0] exp_word(input int i);
        return W'((i * 37) ^ (i >> 2)) ^ W'(base);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Handshake legality monitor at chain ends
    int   prot_err = 0;
    logic pv_rq0 = 1'b0, pv_ak0 = 1'b0, pv_rqe = 1'b0, pv_ake = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pv_ak0 && pv_rq0 && !ak[0]) prot_err++;
            if (!pv_ak0 && ak[0] && !pv_rq0) prot_err++;
            if (pv_rqe && !pv_ake && !rq[STAGES]) prot_err++;
        end
        pv_rq0 = rq[0]; pv_ak0 = ak[0]; pv_rqe = rq[STAGES]; pv_ake = ak[STAGES];
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, LIMIT);
            finish_run();
        end
    end

    int sent = 0;
    int recv = 0;

    task automatic source();
        for (int i = 0; i < NWORDS; i++) begin
            tick($urandom_range(0, 4));
            p_data = exp_word(i);
            p_req  = 1'b1;
            while (!ak[0]) @(negedge clk);
            sent++;
            p_req = 1'b0;
            while (ak[0]) @(negedge clk);
        end
    endtask

    task automatic sink();
        tick(30);
        // R9: all stages full while the sink is stalled
        chk("R9 fill", 32'(sent), 32'(STAGES));
        chk("R9 all closed", {29'd0, lt[0], lt[1], lt[2]}, 32'h7);
        while (recv < NWORDS) begin
            while (!rq[STAGES]) @(negedge clk);
            chk("R9 order", 32'(dt[STAGES]), 32'(exp_word(recv)));
            recv++;
            tick($urandom_range(0, 4));
            p_aout = 1'b1;
            while (rq[STAGES]) @(negedge clk);
            tick($urandom_range(0, 3));
            p_aout = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        base = 8'($urandom_range(0, 255));
        tick(3);
        // R1: reset state
        chk("R1 ack_in", {n_ack, h_ack}, 0);
        chk("R1 req_out", {n_rout, h_rout}, 0);
        chk("R1 lat_closed", {n_lat, h_lat}, 0);
        rst_n = 1'b1;
        tick(1);

        s_data = 8'hA5; s_req = 1'b1;
        tick(1);
        chk("R2 ack/lat", {n_ack, n_lat, h_ack, h_lat}, 4'hF);
        chk("R2 data", {n_dout, h_dout}, 16'hA5A5);
        chk("R5 no req yet", {n_rout, h_rout}, 0);
        tick(1);
        chk("R5 req rise", {n_rout, h_rout}, 2'b11);
        tick(2);
        chk("R3 ack held", {n_ack, h_ack}, 2'b11);
        chk("R8 no recapture", {n_dout, h_dout}, 16'hA5A5);
        s_req = 1'b0; s_data = 8'h00;
        tick(1);
        // R3: input recovers with output stalled
        chk("R3 recovery", {n_ack, h_ack, n_rout, h_rout}, 4'b0011);
        tick(3);
        chk("R4 data held", {n_dout, h_dout}, 16'hA5A5);
        chk("R5 req held", {n_rout, h_rout}, 2'b11);

        // R8: new request while latch closed
        s_data = 8'h77; s_req = 1'b1;
        tick(3);
        chk("R8 ignored ack", {n_ack, h_ack}, 0);
        chk("R8 ignored data", {n_dout, h_dout}, 16'hA5A5);

        s_aout = 1'b1;
        tick(1);
        chk("R5 req fall", {n_rout, h_rout}, 0);
        chk("R6 reopen", 32'(n_lat), 0);
        chk("R7 hold closed", 32'(h_lat), 1);
        tick(1);
        chk("R6 next capture", {n_ack, n_lat, 8'(n_dout)}, {2'b11, 8'h77});
        chk("R7 still closed", {h_lat, h_ack, 8'(h_dout)}, {2'b10, 8'hA5});
        s_aout = 1'b0;
        tick(1);
        chk("R7 reopen", 32'(h_lat), 0);
        chk("R5 waits busy", 32'(n_rout), 0);
        tick(1);
        chk("R7 capture", {h_ack, h_lat, 8'(h_dout)}, {2'b11, 8'h77});
        chk("R5 after busy", 32'(n_rout), 1);
        s_req = 1'b0;
        tick(2);

        fork
            source();
            sink();
        join
        tick(2);
        chk("R9 count", 32'(recv), 32'(NWORDS));
        chk("R3 R5 protocol", 32'(prot_err), 0);
        finish_run();
    end

endmodule